// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses a memory controller presents on each beat of one SDRAM burst. A one-cycle start pulse loads an 8-bit start column together with a burst-length code and an ordering choice. From the next cycle the block drives one column per clock, with a valid flag and a flag on the final beat, until the burst has run its length or a stop input ends it.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block that holds the start column. Only the low bits move, either counting upward with wrap or stepping as the start column XOR the beat number. A full-page burst steps through all 256 columns, wrapping from the top column to zero, and ends only when stopped. A write issued while single-write mode is on always gets a one-beat burst. A new start pulse takes effect at once, so bursts can run back to back with no idle cycle between them.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, valid and last are 0.
- R2: A start pulse sampled on a clock edge makes valid 1 and col equal to start_col in the following cycle (beat 0).
- R3: In sequential order with burst length BL of 2, 4 or 8, beat n drives the upper column bits of start_col unchanged and low log2(BL) bits equal to (start_col + n) mod BL. last is 1 on beat BL-1 only, and valid drops the cycle after it unless a start is sampled.
- R4: In interleave order (ilv_mode=1) with BL of 2, 4 or 8, beat n drives start_col with its low log2(BL) bits XORed with n.
- R5: len_sel codes are 0 for 1 beat, 1 for 2 beats, 2 for 4 beats, 3 for 8 beats and 7 for full page. Codes 4, 5 and 6 give 1 beat.
- R6: In full-page mode, beat n drives (start_col + n) mod 256. It wraps from 255 to 0, never raises last and runs until stopped.
- R7: ilv_mode has no effect in full-page mode or with a burst length of 1.
- R8: stop sampled while valid is 1 and start is 0 makes valid 0 in the next cycle, at any burst length. stop sampled while idle has no effect.
- R9: A start sampled during a burst, including on its last beat, restarts at beat 0 of the new burst in the next cycle.
- R10: When wr_op and single_wr are both 1 with the start pulse, the burst is 1 beat whatever len_sel holds. With either of them 0, len_sel applies.
- R11: last is never 1 while valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a burst from start_col |
| start_col | input | 8 | First column of the burst |
| len_sel | input | 3 | Burst-length code |
| ilv_mode | input | 1 | 1 selects interleave order |
| wr_op | input | 1 | The starting access is a write |
| single_wr | input | 1 | Single-write mode: writes use one beat |
| stop | input | 1 | End the running burst |
| col | output | 8 | Column for the current beat |
| valid | output | 1 | col holds a burst beat |
| last | output | 1 | Final beat of a fixed-length burst |

## Verification
On every cycle the assertions check the following: the start column is loaded on the cycle after a start, a stop or a final beat drops valid, last never appears without valid, and each full-page beat is one column above the previous one with wrap. Other behaviour only shows up in the bench's scenarios, which compare the column against an independent model. This covers the exact sequential and interleave beat orders, the mapping of each length code, the single-write override, and the fact that interleave is ignored for full page and for one-beat bursts.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_sel,
  input  logic             ilv_mode,
  input  logic             wr_op,
  input  logic             single_wr,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last
);
  localparam logic [COL_W-1:0] ONES = '1;

  logic [2:0]       eff_sel;
  logic [COL_W-1:0] sel_mask;
  logic [COL_W-1:0] base_r, cnt_r, mask_r;
  logic             ilv_r, full_r, valid_r;

  assign eff_sel = (wr_op && single_wr) ? 3'd0 : len_sel;

  always_comb begin
    case (eff_sel)
      3'd1:    sel_mask = COL_W'(1);
      3'd2:    sel_mask = COL_W'(3);
      3'd3:    sel_mask = COL_W'(7);
      3'd7:    sel_mask = ONES;
      default: sel_mask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_r <= 1'b0;
      base_r  <= '0;
      cnt_r   <= '0;
      mask_r  <= '0;
      ilv_r   <= 1'b0;
      full_r  <= 1'b0;
    end else if (start) begin
      valid_r <= 1'b1;
      base_r  <= start_col;
      cnt_r   <= '0;
      mask_r  <= sel_mask;
      full_r  <= (eff_sel == 3'd7);
      ilv_r   <= ilv_mode && (eff_sel inside {3'd1, 3'd2, 3'd3});
    end else if (valid_r) begin
      if (stop || last) valid_r <= 1'b0;
      else              cnt_r   <= cnt_r + 1'b1;
    end
  end

  assign col   = (base_r & ~mask_r) |
                 ((ilv_r ? (base_r ^ cnt_r) : (base_r + cnt_r)) & mask_r);
  assign valid = valid_r;
  assign last  = valid_r && !full_r && (cnt_r == mask_r);
endmodule

module sdram_burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic [COL_W-1:0] col,
  input logic             valid,
  input logic             last,
  input logic             full_r
);
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (valid && col == $past(start_col))); // R2
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !valid); // R3
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && stop && !start) |=> !valid); // R8
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid); // R11
  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && full_r && !start && !stop) |=> (valid && col == COL_W'($past(col) + 1'b1))); // R6
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col), .stop(stop),
  .col(col), .valid(valid), .last(last), .full_r(full_r)
);

// File: tb/sim_sdram_burst_colgen.sv
module sim_sdram_burst_colgen;
  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, ilv = 0, wo = 0, sw = 0, sp = 0;
  logic [7:0] sc = 0;
  logic [2:0] sel = 0;
  logic [7:0] col;
  logic valid, last;

  int n_chk = 0, n_bad = 0;
  bit m_v = 0, m_ilv = 0;
  int m_start = 0, m_n = 0, m_bl = 1;
  string cur_tag = "R3";

  always #2 clk = ~clk;

  sdram_burst_colgen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(sc), .len_sel(sel),
    .ilv_mode(ilv), .wr_op(wo), .single_wr(sw), .stop(sp),
    .col(col), .valid(valid), .last(last)
  );

  function automatic int dec_len(int s, bit w, bit s1);
    if (w && s1) return 1;
    case (s)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(int st, int n, int bl, bit il);
    int blk, lo, off;
    if (bl == 0) return (st + n) % 256;
    if (bl == 1) return st;
    blk = st & ~(bl - 1);
    lo  = st & (bl - 1);
    off = il ? (lo ^ n) : ((lo + n) % bl);
    return blk | off;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit st, int c, int s, bit il, bit w, bit s1, bit p);
    bit exp_last;
    @(negedge clk);
    exp_last = m_v && m_bl != 0 && m_n == m_bl - 1;
    check(cur_tag, int'(valid), int'(m_v));
    check("R11", int'(last), int'(exp_last));
    if (m_v)
      check(m_n == 0 ? "R2" : (m_bl == 0 ? "R6" : (m_ilv ? "R4" : "R3")),
            int'(col), exp_col(m_start, m_n, m_bl, m_ilv));
    start = st; sc = 8'(c); sel = 3'(s); ilv = il; wo = w; sw = s1; sp = p;
    if (st) begin
      m_v = 1; m_start = c; m_n = 0; m_bl = dec_len(s, w, s1);
      m_ilv = il && (m_bl inside {2, 4, 8});
    end else if (m_v) begin
      if (p || exp_last) m_v = 0;
      else m_n++;
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(valid), 0);
    check("R1", int'(last), 0);
    rst_n = 1;
    cur_tag = "R1"; idle(2);
    cur_tag = "R5";
    cyc(1, 'h35, 3, 0, 0, 0, 0); idle(10);
    cyc(1, 'h35, 5, 0, 0, 0, 0); idle(3);
    cyc(1, 'h42, 1, 0, 0, 0, 0); idle(3);
    cyc(1, 'h42, 2, 0, 0, 0, 0); idle(6);
    cur_tag = "R4";
    cyc(1, 'h35, 3, 1, 0, 0, 0); idle(10);
    cyc(1, 'h16, 2, 1, 0, 0, 0); idle(6);
    cur_tag = "R7";
    cyc(1, 'hFD, 7, 1, 0, 0, 0); idle(6);
    cur_tag = "R8";
    cyc(0, 0, 0, 0, 0, 0, 1); idle(2);
    cyc(0, 0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 0, 1); idle(2);
    cyc(1, 'h11, 4, 1, 0, 0, 0); idle(3);
    cur_tag = "R6";
    cyc(1, 'hF0, 7, 0, 0, 0, 0); idle(280);
    cur_tag = "R8";
    cyc(0, 0, 0, 0, 0, 0, 1); idle(3);
    cyc(1, 'h20, 3, 0, 0, 0, 0); idle(2); cyc(0, 0, 0, 0, 0, 0, 1); idle(3);
    cur_tag = "R9";
    cyc(1, 'h20, 3, 0, 0, 0, 0); idle(3);
    cyc(1, 'h87, 2, 1, 0, 0, 0); idle(3);
    cyc(1, 'h50, 1, 0, 0, 0, 0); cyc(1, 'h61, 1, 0, 0, 0, 0);
    cyc(1, 'h72, 0, 0, 0, 0, 0); idle(4);
    cur_tag = "R10";
    cyc(1, 'h33, 3, 0, 1, 1, 0); idle(3);
    cyc(1, 'h33, 7, 0, 1, 1, 0); idle(3);
    cyc(1, 'h33, 3, 0, 1, 0, 0); idle(10);
    cyc(1, 'h33, 3, 0, 0, 1, 0); idle(10);
    cur_tag = "R3";
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      int sl;
      sl = $urandom_range(0, 5);
      cyc(($urandom_range(0, 5) == 0), int'($urandom_range(0, 255)),
          (sl == 4) ? 7 : ((sl == 5) ? 6 : sl),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 19) == 0));
    end
    idle(300);
    cyc(0, 0, 0, 0, 0, 0, 1); idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule